// File: doc/BRIEF.md
# Median Reference Search Controller

This block finds the comparison reference code at which a key array yields about as many ones as zeros. A key bit is 1 when a cell's current exceeds the reference. Raising the code therefore lowers the number of ones. On a start pulse the controller loads a caller-supplied initial code and a tolerance. It then reads every cell of the array once through a pipelined read-request port and counts the ones that come back.

If the count lies inside the tolerance window around half the array size, the controller locks. If the count is above the window it raises the code by one step. If the count is below the window it lowers the code by one step. After a step it reads the whole array again. The search gives up with an error if the code would have to leave its range, or if a set number of passes goes by without a lock. Calibration is meant to run once, right after the array has been put in its first reset state. The reference source and the array itself are outside the block.

Top module: `refcal_ctrl`

## Requirements
- R1: After reset, busy, done, locked, err and rd_req are all 0.
- R2: A start pulse while idle loads init_code into ref_code and raises busy, both visible in the next cycle.
- R3: Each pass issues exactly ROWS*COLS read requests, one per cycle, in row-major order: column increments first, row on column wrap, starting from row 0, column 0. rd_req is only ever high while busy.
- R4: The window is [N/2 - tol, N/2 + tol] inclusive, with N = ROWS*COLS, clipped to [0, N]. A pass whose ones count falls inside it ends the search with locked=1, err=0, and ref_code left at the code used for that pass.
- R5: A pass with more ones than the window's upper bound increments ref_code by one and starts another pass.
- R6: A pass with fewer ones than the window's lower bound decrements ref_code by one and starts another pass.
- R7: If a step would take ref_code above all-ones or below zero, the search ends with err=1, locked=0, and ref_code held at that limit.
- R8: If pass number ITER_MAX ends outside the window, the search ends with err=1 and the code of that pass. A lock on that same pass wins over the limit.
- R9: locked and err are never both 1. done is a single-cycle pulse at the end of each search, with busy already low.
- R10: A start pulse during a search is ignored: the outcome equals that of the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (ignored while busy) |
| init_code | input | CODE_W | First reference code tried |
| tol | input | $clog2(ROWS*COLS+1) | Half-width of the acceptance window, in bits |
| rd_req | output | 1 | Read request for the addressed cell |
| rd_row | output | $clog2(ROWS) | Row address of the request |
| rd_col | output | $clog2(COLS) | Column address of the request |
| rd_valid | input | 1 | Returned key bit is valid |
| rd_bit | input | 1 | Returned key bit |
| ref_code | output | CODE_W | Current / final reference code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| locked | output | 1 | Search ended inside the window |
| err | output | 1 | Search ended at a code limit or the pass limit |

## Verification
Two coincidences are provoked. In the first, a second start arrives while a search is under way, so the cycle that launches a new pass can also see start. In the second, the final allowed pass ends at a code limit or at the pass limit, so the lock, limit and saturation decisions meet in one judgement cycle. Uniform arrays at both extreme conductances push the search into each code limit, and random conductance maps with random tolerances mix locks on the last allowed pass with exhaustion. Every outcome is compared with a bench model of the search that recounts the ones at each code.

// File: rtl/refcal_pkg.sv
package refcal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE,
    CAL_SCAN,
    CAL_JUDGE
  } cal_state_t;

  typedef enum logic [1:0] {
    DIR_HOLD,
    DIR_UP,
    DIR_DOWN
  } step_dir_t;
endpackage

// File: rtl/refcal_addr_gen.sv
module refcal_addr_gen #(
  parameter int ROWS = 64,
  parameter int COLS = 128,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          req,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      row <= '0;
      col <= '0;
    end else if (go) begin
      req <= 1'b1;
      row <= '0;
      col <= '0;
    end else if (req) begin
      if (col == COL_LAST) begin
        col <= '0;
        if (row == ROW_LAST) begin
          req <= 1'b0;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refcal_tally.sv
module refcal_tally #(
  parameter int NBITS = 8192,
  localparam int CNT_W = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             valid,
  input  logic             bit_in,
  output logic [CNT_W-1:0] ones,
  output logic             fin
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);
  logic [CNT_W-1:0] got;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      got  <= '0;
      ones <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (en && valid) begin
        got  <= got + 1'b1;
        ones <= ones + CNT_W'(bit_in);
        if (got == LAST) begin
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/refcal_judge.sv
module refcal_judge
  import refcal_pkg::*;
#(
  parameter int NBITS = 8192,
  localparam int CNT_W = $clog2(NBITS + 1)
) (
  input  logic [CNT_W-1:0] ones,
  input  logic [CNT_W-1:0] tol,
  output step_dir_t        dir
);
  localparam logic [CNT_W:0] FULL = (CNT_W + 1)'(NBITS);
  localparam logic [CNT_W:0] HALF = (CNT_W + 1)'(NBITS / 2);

  logic [CNT_W:0] tol_x, ones_x, lo, hi;

  always_comb begin
    tol_x  = {1'b0, tol};
    ones_x = {1'b0, ones};
    lo     = (tol_x >= HALF) ? '0 : HALF - tol_x;
    hi     = (tol_x >= FULL - HALF) ? FULL : HALF + tol_x;
    if (ones_x > hi) begin
      dir = DIR_UP;
    end else if (ones_x < lo) begin
      dir = DIR_DOWN;
    end else begin
      dir = DIR_HOLD;
    end
  end
endmodule

// File: rtl/refcal_ctrl.sv
module refcal_ctrl
  import refcal_pkg::*;
#(
  parameter int ROWS     = 64,
  parameter int COLS     = 128,
  parameter int CODE_W   = 8,
  parameter int ITER_MAX = 255
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [CODE_W-1:0]                init_code,
  input  logic [$clog2(ROWS*COLS+1)-1:0]   tol,
  output logic                             rd_req,
  output logic [$clog2(ROWS)-1:0]          rd_row,
  output logic [$clog2(COLS)-1:0]          rd_col,
  input  logic                             rd_valid,
  input  logic                             rd_bit,
  output logic [CODE_W-1:0]                ref_code,
  output logic                             busy,
  output logic                             done,
  output logic                             locked,
  output logic                             err
);
  localparam int NBITS  = ROWS * COLS;
  localparam int CNT_W  = $clog2(NBITS + 1);
  localparam int ITER_W = $clog2(ITER_MAX + 1);
  localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(ITER_MAX - 1);

  cal_state_t       state;
  step_dir_t        dir;
  logic [CNT_W-1:0] tol_q;
  logic [CNT_W-1:0] ones;
  logic [ITER_W-1:0] iter;
  logic             go;
  logic             fin;
  logic             at_edge;

  refcal_addr_gen #(.ROWS(ROWS), .COLS(COLS)) u_addr (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .req (rd_req),
    .row (rd_row),
    .col (rd_col)
  );

  refcal_tally #(.NBITS(NBITS)) u_tally (
    .clk    (clk),
    .rst    (rst),
    .clr    (go),
    .en     (state == CAL_SCAN),
    .valid  (rd_valid),
    .bit_in (rd_bit),
    .ones   (ones),
    .fin    (fin)
  );

  refcal_judge #(.NBITS(NBITS)) u_judge (
    .ones (ones),
    .tol  (tol_q),
    .dir  (dir)
  );

  always_comb begin
    at_edge = ((dir == DIR_UP) && (ref_code == '1)) ||
              ((dir == DIR_DOWN) && (ref_code == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CAL_IDLE;
      ref_code <= '0;
      tol_q    <= '0;
      iter     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      locked   <= 1'b0;
      err      <= 1'b0;
      go       <= 1'b0;
    end else begin
      done <= 1'b0;
      go   <= 1'b0;
      unique case (state)
        CAL_IDLE: begin
          if (start) begin
            ref_code <= init_code;
            tol_q    <= tol;
            iter     <= '0;
            locked   <= 1'b0;
            err      <= 1'b0;
            busy     <= 1'b1;
            go       <= 1'b1;
            state    <= CAL_SCAN;
          end
        end
        CAL_SCAN: begin
          if (fin) begin
            state <= CAL_JUDGE;
          end
        end
        CAL_JUDGE: begin
          if (dir == DIR_HOLD) begin
            locked <= 1'b1;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= CAL_IDLE;
          end else if (at_edge || (iter == ITER_LAST)) begin
            err   <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= CAL_IDLE;
          end else begin
            ref_code <= (dir == DIR_UP) ? ref_code + 1'b1 : ref_code - 1'b1;
            iter     <= iter + 1'b1;
            go       <= 1'b1;
            state    <= CAL_SCAN;
          end
        end
        default: state <= CAL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refcal_chk.sv
module refcal_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              locked,
  input logic              err,
  input logic              rd_req,
  input logic [CODE_W-1:0] ref_code
);
  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(locked && err));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_req_busy_R3: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // R5 and R6: a running search moves the code by at most one step
  assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      (ref_code == $past(ref_code) ||
       ref_code == CODE_W'($past(ref_code) + 1'b1) ||
       ref_code == CODE_W'($past(ref_code) - 1'b1)));
endmodule

bind refcal_ctrl refcal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .locked   (locked),
  .err      (err),
  .rd_req   (rd_req),
  .ref_code (ref_code)
);

// File: tb/sim_refcal_ctrl.sv
`timescale 1ns/1ps
module sim_refcal_ctrl;
  localparam int ROWS = 8;
  localparam int COLS = 16;
  localparam int N = ROWS * COLS;
  localparam int CODE_W = 8;
  localparam int ITERS = 12;
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CODE_W-1:0] init_code = '0;
  logic [CNT_W-1:0] tol = '0;
  logic rd_req, rd_valid, rd_bit;
  logic [$clog2(ROWS)-1:0] rd_row;
  logic [$clog2(COLS)-1:0] rd_col;
  logic [CODE_W-1:0] ref_code;
  logic busy, done, locked, err;

  int g [N];
  int nchk = 0, nfail = 0;
  int exp_idx = 0, addr_bad = 0, req_cnt = 0, done_cnt = 0;

  always #2.5 clk = ~clk;

  refcal_ctrl #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W), .ITER_MAX(ITERS)) u0 (
    .clk(clk), .rst(rst), .start(start), .init_code(init_code), .tol(tol),
    .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
    .rd_valid(rd_valid), .rd_bit(rd_bit), .ref_code(ref_code),
    .busy(busy), .done(done), .locked(locked), .err(err)
  );

  // array model: bit is 1 when cell conductance exceeds the reference
  always @(posedge clk) begin
    rd_valid <= rd_req;
    rd_bit   <= (g[int'(rd_row) * COLS + int'(rd_col)] > int'(ref_code));
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_req) begin
        if (int'(rd_row) * COLS + int'(rd_col) != exp_idx) addr_bad++;
        exp_idx = (exp_idx + 1) % N;
        req_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int count_ones(input int code);
    int c = 0;
    for (int i = 0; i < N; i++) if (g[i] > code) c++;
    return c;
  endfunction

  function automatic void model(input int init, input int tl, output int code,
                                output bit lk, output bit er, output int passes);
    int lo, hi, ones;
    code = init; lk = 0; er = 0; passes = 0;
    lo = (tl >= N / 2) ? 0 : N / 2 - tl;
    hi = (tl >= N - N / 2) ? N : N / 2 + tl;
    for (int k = 1; k <= ITERS; k++) begin
      passes = k;
      ones = count_ones(code);
      if (ones >= lo && ones <= hi) begin lk = 1; return; end
      if ((ones > hi && code == 255) || (ones < lo && code == 0) || k == ITERS) begin
        er = 1; return;
      end
      code = (ones > hi) ? code + 1 : code - 1;
    end
  endfunction

  task automatic run(input int init, input int tl, input bit restart);
    int ecode, epass, waitc;
    bit elk, eer;
    model(init, tl, ecode, elk, eer, epass);
    req_cnt = 0; done_cnt = 0; addr_bad = 0; exp_idx = 0;
    @(negedge clk);
    start = 1'b1; init_code = CODE_W'(init); tol = CNT_W'(tl);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && int'(ref_code) == init, "R2 load", int'(ref_code), init);
    if (restart) begin
      @(negedge clk);
      start = 1'b1; init_code = CODE_W'(init ^ 8'h5a); tol = '0;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 20000) begin @(negedge clk); waitc++; end
    chk(int'(ref_code) == ecode, "R4-R8 code", int'(ref_code), ecode);
    chk(locked == elk, "R4 locked", int'(locked), int'(elk));
    chk(err == eer, "R7/R8 err", int'(err), int'(eer));
    chk(busy == 1'b0, "R9 idle at done", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
    chk(req_cnt == epass * N, "R3 request count", req_cnt, epass * N);
    chk(addr_bad == 0, "R3 address order", addr_bad, 0);
    if (restart) chk(int'(ref_code) == ecode && locked == elk, "R10 restart ignored",
                     int'(ref_code), ecode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) g[i] = int'($urandom_range(255, 0));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !locked && !err && !rd_req, "R1 reset state",
        int'({busy, done, locked, err, rd_req}), 0);
    run(128, 32, 0);          // R4 wide window
    run(100, 100, 0);         // R4 tolerance beyond half
    run(118, 5, 0);           // R5 climbing
    run(140, 5, 0);           // R6 falling
    run(90, 2, 0);            // R8 too far for the pass limit
    run(135, 4, 1);           // R10 second start mid-search
    for (int i = 0; i < N; i++) g[i] = 256;
    run(250, 8, 0);           // R7 saturate high
    for (int i = 0; i < N; i++) g[i] = 0;
    run(3, 8, 0);             // R7 saturate low
    for (int i = 0; i < N; i++) g[i] = int'($urandom_range(255, 0));
    for (int r = 0; r < 10; r++)
      run(116 + int'($urandom_range(24, 0)), int'($urandom_range(12, 0)), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule